// File: doc/BRIEF.md
# Mean-Removed Sum-of-Squares Accumulator

This block computes the central part of a standard-deviation calculation over a short stream of fixed-point samples. Each sample is a signed 32-bit word with 10 integer bits and 22 fraction bits. A start pulse captures a mean value, a point count and a rescale selection, and clears the running total. Every accepted sample has the mean taken away. The difference is squared at full precision, and the square is shifted right by 22 or 12 bits before it is added to a 64-bit total.

Samples arrive over a ready/valid handshake at up to one per clock. One register stage sits after the multiplier, so a back-to-back stream is sustained. When the programmed number of samples has been consumed and the last product has been added, a one-cycle done strobe is raised. The total then stays on the sum output until the next start. The division by the point count and the square root are left to the consumer.

Top module: `msq_accum`

## Requirements
- R1: A start pulse while idle captures mean, count and shift selection, clears the sum to zero in the next cycle, and makes the block busy.
- R2: A start pulse while busy is ignored: the run in progress keeps its original mean, count and shift, and its result does not change.
- R3: in_ready_o is high only while the block is collecting samples. A sample is taken on each rising edge where in_valid_i and in_ready_o are both high, so it can take one per cycle.
- R4: The difference sample minus mean is formed in 33 bits and squared without loss, so differences beyond the 32-bit range (for example 0x7FFFFFFF minus 0x80000000) give the exact square.
- R5: Each square is shifted right before it is added. With shift_sel_i = 0 the shift is 22 bits; with shift_sel_i = 1 it is 12 bits. The value is sampled at start.
- R6: The sum is 64 bits wide and never wraps or truncates to 32 bits. Totals above 2^32 are reported exactly, and the sum never decreases during a run.
- R7: A count of N in 1..255 makes the block take exactly N samples. A count of 0 is treated as 1.
- R8: done_o is high for exactly one cycle, in the cycle after the last sample's product has been added. sum_o then holds that total unchanged until the next accepted start.
- R9: After reset, in_ready_o, busy_o and done_o are low and sum_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a run; ignored while busy |
| mean_i | input | 32 | Mean to remove, signed Q10.22, captured at start |
| count_i | input | 8 | Number of samples; 0 is treated as 1 |
| shift_sel_i | input | 1 | 0: shift squares right by 22, 1: by 12 |
| in_valid_i | input | 1 | Sample present on in_data_i |
| in_data_i | input | 32 | Sample, signed Q10.22 |
| in_ready_o | output | 1 | Block will take a sample this cycle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle strobe: sum_o is final |
| sum_o | output | 64 | Accumulated rescaled squares |

## Verification
The hardest condition to reach from the ports is a start pulse that lands in the middle of a run while samples trickle in with gaps. Only that shows whether the captured mean and count survive. The stimulus raises start with a different mean and count after the second accepted sample of selected runs. It then compares the final total with the value for the original settings. Separate directed runs cover a 255-sample stream of extreme values with the 12-bit shift, which drives the total well past 32 bits, and a sample/mean pair whose difference needs the 33rd bit.

// File: rtl/msq_pkg.sv
package msq_pkg;
    parameter int DATA_W      = 32;
    parameter int CNT_W       = 8;
    parameter int ACC_W       = 64;
    parameter int SHIFT_WIDE  = 22;
    parameter int SHIFT_FINE  = 12;
    localparam int DIFF_W     = DATA_W + 1;
    localparam int PROD_W     = 2 * DIFF_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] mean;
        logic              fine;
    } run_cfg_t;

    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] sq;
    } prod_t;

    function automatic logic [ACC_W-1:0] rescale(input logic [PROD_W-1:0] sq,
                                                 input logic fine);
        logic signed [PROD_W-1:0] s;
        logic signed [PROD_W-1:0] r;
        s = $signed(sq);
        r = fine ? (s >>> SHIFT_FINE) : (s >>> SHIFT_WIDE);
        return r[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/msq_ctrl.sv
module msq_ctrl
    import msq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] mean_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              fine_in,
    input  logic              in_valid,
    output logic              ready,
    output logic              busy,
    output logic              clear,
    output logic              take,
    output logic              done,
    output run_cfg_t          cfg
);
    run_state_t         state;
    logic [CNT_W-1:0]   left;

    assign ready = (state == ST_RUN);
    assign busy  = (state != ST_IDLE);
    assign clear = start && (state == ST_IDLE);
    assign take  = ready && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            left  <= '0;
            done  <= 1'b0;
            cfg   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    cfg.mean <= mean_in;
                    cfg.fine <= fine_in;
                    left     <= (count_in == '0) ? CNT_W'(1) : count_in;
                    state    <= ST_RUN;
                end
                ST_RUN: if (take) begin
                    if (left == CNT_W'(1)) state <= ST_DRAIN;
                    left <= left - CNT_W'(1);
                end
                ST_DRAIN: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msq_square.sv
module msq_square
    import msq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] mean,
    output prod_t             prod
);
    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] dext;
    logic signed [PROD_W-1:0] sq;

    always_comb begin
        diff = $signed({sample[DATA_W-1], sample}) - $signed({mean[DATA_W-1], mean});
        dext = PROD_W'(diff);
        sq   = dext * dext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else begin
            prod.vld <= take;
            if (take) prod.sq <= sq;
        end
    end
endmodule

// File: rtl/msq_acc.sv
module msq_acc
    import msq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  prod_t            prod,
    input  logic             fine,
    output logic [ACC_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (rst || clear) total <= '0;
        else if (prod.vld) total <= total + rescale(prod.sq, fine);
    end
endmodule

// File: rtl/msq_accum.sv
module msq_accum
    import msq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mean_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              shift_sel_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  sum_o
);
    logic     clear;
    logic     take;
    run_cfg_t cfg;
    prod_t    prod;

    msq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .mean_in(mean_i),
        .count_in(count_i), .fine_in(shift_sel_i), .in_valid(in_valid_i),
        .ready(in_ready_o), .busy(busy_o), .clear(clear), .take(take),
        .done(done_o), .cfg(cfg)
    );

    msq_square u_sq (
        .clk(clk), .rst(rst), .take(take), .sample(in_data_i),
        .mean(cfg.mean), .prod(prod)
    );

    msq_acc u_acc (
        .clk(clk), .rst(rst), .clear(clear), .prod(prod),
        .fine(cfg.fine), .total(sum_o)
    );
endmodule

// File: rtl/msq_accum_chk.sv
module msq_accum_chk
    import msq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             in_ready_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [ACC_W-1:0] sum_o
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (sum_o == '0 && busy_o)); // R1
    AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> busy_o); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (sum_o >= $past(sum_o))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !in_ready_o)); // R8
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(sum_o)); // R8
endmodule

bind msq_accum msq_accum_chk u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .in_ready_o(in_ready_o),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o)
);

// File: tb/msq_accum_test.sv
module msq_accum_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] mean_i = '0;
    logic [7:0]  count_i = '0;
    logic        shift_sel_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_data_i = '0;
    logic        in_ready_o, busy_o, done_o;
    logic [63:0] sum_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] smp [256];

    always #5 clk = ~clk;

    msq_accum uut (
        .clk(clk), .rst(rst), .start_i(start_i), .mean_i(mean_i),
        .count_i(count_i), .shift_sel_i(shift_sel_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_ready_o(in_ready_o), .busy_o(busy_o),
        .done_o(done_o), .sum_o(sum_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input int n, input logic [31:0] m,
                                          input bit fine);
        logic [63:0] acc = '0;
        for (int i = 0; i < n; i++) begin
            logic signed [65:0] d;
            logic signed [65:0] sq;
            d  = 66'($signed(smp[i])) - 66'($signed(m));
            sq = d * d;
            sq = fine ? (sq >>> 12) : (sq >>> 22);
            acc += sq[63:0];
        end
        return acc;
    endfunction

    task automatic run(input logic [7:0] cnt, input logic [31:0] m, input bit fine,
                       input bit gaps, input bit inject, input string tag);
        int n = (cnt == 0) ? 1 : int'(cnt);
        int idx = 0;
        int wait_cyc = 0;
        bit seen_done = 0;
        bit extra_ready = 0;
        logic [63:0] exp = model(n, m, fine);
        @(negedge clk);
        start_i = 1; mean_i = m; count_i = cnt; shift_sel_i = fine;
        @(negedge clk);
        start_i = 0;
        check(sum_o == 0 && busy_o, "R1", sum_o, 0);
        while (!seen_done && wait_cyc < 3000) begin
            if (done_o) begin
                seen_done = 1;
                break;
            end
            if (idx >= n && in_ready_o) extra_ready = 1;
            start_i = 0;
            if (inject && idx == 2) begin
                start_i = 1; mean_i = $urandom; count_i = 8'd3; shift_sel_i = ~fine;
            end
            if (idx < n && (!gaps || ($urandom % 4) != 0)) begin
                in_valid_i = 1; in_data_i = smp[idx];
                if (in_ready_o) idx++;
            end else begin
                in_valid_i = 0; in_data_i = $urandom;
            end
            @(negedge clk);
            wait_cyc++;
        end
        start_i = 0; in_valid_i = 0;
        check(seen_done, {tag, " R8 done"}, 64'(seen_done), 1);
        check(sum_o == exp, {tag, " sum"}, sum_o, exp);
        check(!extra_ready && idx == n, "R7 sample count", 64'(idx), 64'(n));
        // idle: offer samples, ready must stay low and sum must hold
        in_valid_i = 1; in_data_i = 32'h1234_5678;
        @(negedge clk);
        check(!done_o, "R8 single-cycle done", 64'(done_o), 0);
        check(!in_ready_o, "R3 ready low when idle", 64'(in_ready_o), 0);
        @(negedge clk);
        in_valid_i = 0;
        check(sum_o == exp, "R8 sum held", sum_o, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!in_ready_o && !busy_o && !done_o && sum_o == 0, "R9 reset", sum_o, 0);

        // count 0 behaves as one sample (R7)
        smp[0] = 32'h0100_0000; smp[1] = 32'h7FFF_FFFF;
        run(8'd0, 32'h0040_0000, 1'b0, 1'b0, 1'b0, "R7 count0");
        run(8'd1, 32'h0040_0000, 1'b1, 1'b0, 1'b0, "R7 count1");

        // 33-bit difference (R4)
        smp[0] = 32'h7FFF_FFFF; smp[1] = 32'h8000_0000;
        run(8'd1, 32'h8000_0000, 1'b1, 1'b0, 1'b0, "R4 wide diff");
        run(8'd2, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, "R4 wide diff b");

        // long extreme run past 32 bits, both shifts (R6, R5)
        for (int i = 0; i < 256; i++) smp[i] = (i % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        run(8'd255, 32'h0000_0000, 1'b1, 1'b0, 1'b0, "R6 large");
        check(sum_o > 64'hFFFF_FFFF, "R6 exceeds 32 bits", sum_o, 64'h1_0000_0000);
        run(8'd255, 32'h0000_0000, 1'b0, 1'b1, 1'b0, "R5 shift22");

        // mid-run start ignored (R2)
        for (int i = 0; i < 256; i++) smp[i] = $urandom;
        run(8'd9, 32'h0123_4567, 1'b1, 1'b1, 1'b1, "R2 inject");
        run(8'd6, 32'hFF00_0000, 1'b0, 1'b0, 1'b1, "R2 inject b");

        // random runs, back-to-back and with gaps (R3, R4, R5)
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < 256; i++) smp[i] = $urandom;
            run(8'($urandom), $urandom, 1'($urandom), r[0], 1'b0, "R5 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule